// File: doc/BRIEF.md
# Three-Channel Command Doorbell

A peripheral on the coprocessor side that lets a host processor post commands on three independent channels through a small 32-bit register window. The host writes a request word into a channel's request register: the physical address of a request buffer, with bit 0 set to mark the word as valid. The channel presents that word to the coprocessor, which accepts it with a ready handshake. Later the coprocessor posts a result code for the channel. This raises the channel's completion interrupt. The host reads the code and acknowledges it by writing exactly the same value back to the status register.

A fourth interrupt line carries notifications that the loaded module has changed state, for example loaded, suspended or unloaded. It uses the same read-then-echo acknowledge scheme. The coprocessor recognises the result codes 1 (success), 3 (unknown command), 5 (bad request-buffer address) and 9 (I/O error). The block checks the address tag of each request and reports a malformed one with code 5 without involving the coprocessor. It does not read or check the contents of the request buffer.

Top module: `cmd_doorbell3`

## Requirements
- R1: After reset, all four `irq` bits and all `req_valid` bits are 0, and every register in the window reads 0.
- R2: On an idle channel, a write to the request register whose bits [1:0] equal 2'b01 raises `req_valid` for that channel in the next cycle, with the written word on the channel's slice of `req_addr`. `req_valid` stays high until `req_ready` is seen.
- R3: A cycle with `req_valid` and `req_ready` both high moves the channel to busy, and `req_valid` is low from the next cycle.
- R4: A `post_en` for a busy channel (`post_chan` 0..2) sets that channel's completion interrupt `irq[chan+1]` in the next cycle. The channel's status register then reads `post_code`.
- R5: Writing to the status register a value equal to the posted code clears the completion interrupt in the next cycle, and the status register then reads 0.
- R6: Writing to the status register a value that differs from the posted code has no effect: the interrupt stays high and the status register is unchanged.
- R7: A request write to a channel that is not idle is rejected, and `req_addr` keeps the earlier word. The channel's sticky overrun bit (bit ch of the register at 0x20) is set. Writing 1 to that bit clears it.
- R8: A request write to an idle channel with bits [1:0] other than 2'b01 never raises `req_valid`. It completes in the next cycle with status 5 and the completion interrupt set.
- R9: The request registers for channels 0, 1 and 2 are at 0x14, 0x18 and 0x1C, and their status registers are at 0x04, 0x08 and 0x0C. An access to one channel's registers never changes another channel.
- R10: `evt_post` sets `irq[0]` in the next cycle and latches `evt_code`, which reads at 0x00. A newer event replaces the pending code. An echo of the current code at 0x00 clears `irq[0]`. Any other value written there is ignored.
- R11: A `post_en` addressed to a channel that is idle or still waiting for `req_ready` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host register write strobe |
| bus_addr | input | AW | Host register byte offset |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| req_valid | output | 3 | Per-channel request pending toward the coprocessor |
| req_addr | output | 3*DW | Per-channel request word; channel i in bits [i*DW +: DW] |
| req_ready | input | 3 | Per-channel accept from the coprocessor |
| post_en | input | 1 | Coprocessor posts a result code |
| post_chan | input | 2 | Channel the result belongs to |
| post_code | input | DW | Result code |
| evt_post | input | 1 | State-change notification strobe |
| evt_code | input | EW | Notification code |
| irq | output | 4 | Bit 0 event interrupt, bits 1..3 completion of channels 0..2 |

## Verification
The hardest situations to reach are collisions: a second request that arrives while a channel is still waiting or busy, and an acknowledge that echoes the wrong value. Neither occurs in an orderly host sequence. The bench provokes both on purpose. It re-writes a request register before the coprocessor handshake completes, and it writes a corrupted echo before the correct one. It also posts results to idle and waiting channels, to show that the state stays where it was.

// File: rtl/cmd_doorbell3.sv
module cmd_doorbell3 #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int EW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [2:0]         req_valid,
  output logic [3*DW-1:0]    req_addr,
  input  logic [2:0]         req_ready,
  input  logic               post_en,
  input  logic [1:0]         post_chan,
  input  logic [DW-1:0]      post_code,
  input  logic               evt_post,
  input  logic [EW-1:0]      evt_code,
  output logic [3:0]         irq
);
  localparam int NCH = 3;
  localparam logic [AW-1:0] A_EVT  = AW'(8'h00);
  localparam logic [AW-1:0] A_OVR  = AW'(8'h20);
  localparam logic [DW-1:0] C_BADADDR = DW'(5);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BUSY, S_DONE} ch_st_t;

  ch_st_t          st   [NCH];
  logic [DW-1:0]   rq   [NCH];
  logic [DW-1:0]   sts  [NCH];
  logic [NCH-1:0]  ovr;
  logic [NCH-1:0]  busy;
  logic [NCH-1:0]  hit_req, hit_sts;
  logic            evt_pend;
  logic [EW-1:0]   evt_val;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit_req[i] = bus_we && bus_addr == AW'(8'h14 + 4*i);
    assign hit_sts[i] = bus_we && bus_addr == AW'(4*(i+1));
    assign busy[i]    = st[i] != S_IDLE;
    assign req_valid[i] = st[i] == S_WAIT;
    assign req_addr[i*DW +: DW] = rq[i];
    assign irq[i+1]   = st[i] == S_DONE;
  end
  assign irq[0] = evt_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        st[i]  <= S_IDLE;
        rq[i]  <= '0;
        sts[i] <= '0;
      end
      ovr <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        unique case (st[i])
          S_IDLE: if (hit_req[i]) begin
            rq[i] <= bus_wdata;
            if (bus_wdata[1:0] == 2'b01) st[i] <= S_WAIT;
            else begin
              st[i]  <= S_DONE;
              sts[i] <= C_BADADDR;
            end
          end
          S_WAIT: if (req_ready[i]) st[i] <= S_BUSY;
          S_BUSY: if (post_en && post_chan == 2'(i)) begin
            sts[i] <= post_code;
            st[i]  <= S_DONE;
          end
          S_DONE: if (hit_sts[i] && bus_wdata == sts[i]) begin
            sts[i] <= '0;
            st[i]  <= S_IDLE;
          end
        endcase
        if (hit_req[i] && busy[i]) ovr[i] <= 1'b1;
        else if (bus_we && bus_addr == A_OVR && bus_wdata[i]) ovr[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_pend <= 1'b0;
      evt_val  <= '0;
    end else if (evt_post) begin
      evt_pend <= 1'b1;
      evt_val  <= evt_code;
    end else if (bus_we && bus_addr == A_EVT && evt_pend && bus_wdata == DW'(evt_val)) begin
      evt_pend <= 1'b0;
      evt_val  <= '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_EVT) bus_rdata = DW'(evt_val);
    if (bus_addr == A_OVR) bus_rdata = DW'(ovr);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(4*(i+1)))      bus_rdata = sts[i];
      if (bus_addr == AW'(8'h14 + 4*i))  bus_rdata = rq[i];
    end
  end
endmodule

// File: rtl/cmd_doorbell3_chk.sv
module cmd_doorbell3_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [2:0]    req_valid,
  input logic [2:0]    req_ready,
  input logic          post_en,
  input logic [1:0]    post_chan,
  input logic          evt_post,
  input logic [3:0]    irq,
  input logic [2:0]    busy,
  input logic [2:0]    ovr
);
  for (genvar i = 0; i < 3; i++) begin : g_a
    localparam logic [AW-1:0] SA = AW'(4*(i+1));
    localparam logic [AW-1:0] RA = AW'(8'h14 + 4*i);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] && !req_ready[i] |=> req_valid[i]);
    p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] && req_ready[i] |=> !req_valid[i]);
    p_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && !req_valid[i] && !irq[i+1] && post_en && post_chan == 2'(i) |=> irq[i+1]);
    p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i+1] && bus_we && bus_addr == SA && bus_wdata == bus_rdata |=> !irq[i+1]);
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i+1] && !(bus_we && bus_addr == SA && bus_wdata == bus_rdata) |=> irq[i+1]);
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && bus_we && bus_addr == RA |=> ovr[i]);
    p_badaddr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[i] && bus_we && bus_addr == RA && bus_wdata[1:0] != 2'b01 |=> irq[i+1] && !req_valid[i]);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[i] && !(bus_we && bus_addr == RA) |=> !irq[i+1] && !req_valid[i]);
  end

  p_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_post |=> irq[0]);
endmodule

bind cmd_doorbell3 cmd_doorbell3_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_cmd_doorbell3.sv
module sim_cmd_doorbell3;
  logic        clk = 0, rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0]  req_valid, req_ready = 0;
  logic [95:0] req_addr;
  logic        post_en = 0;
  logic [1:0]  post_chan = 0;
  logic [31:0] post_code = 0;
  logic        evt_post = 0;
  logic [7:0]  evt_code = 0;
  logic [3:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_doorbell3 u0 (.*);

  // {channel, request word, result code}
  localparam logic [65:0] VEC [6] = '{
    {2'd0, 32'h1F85_0001, 32'd1},
    {2'd1, 32'h0000_1001, 32'd3},
    {2'd2, 32'h8000_4001, 32'd9},
    {2'd1, 32'h0000_2003, 32'd0},
    {2'd0, 32'h0000_3000, 32'd0},
    {2'd2, 32'h00AB_CD01, 32'd5}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic take(int ch);
    @(negedge clk); req_ready[ch] = 1;
    @(negedge clk); req_ready[ch] = 0;
  endtask

  task automatic post(int ch, logic [31:0] c);
    @(negedge clk); post_en = 1; post_chan = 2'(ch); post_code = c;
    @(negedge clk); post_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req_valid", 32'(req_valid), 0);
    for (int a = 0; a <= 8'h20; a += 4) begin rd(8'(a), v); chk("R1 readback", v, 0); end

    for (int k = 0; k < 6; k++) begin
      int ch = int'(VEC[k][65:64]);
      logic [31:0] w = VEC[k][63:32];
      logic [31:0] e;
      wr(8'(8'h14 + 4*ch), w);
      if (w[1:0] == 2'b01) begin
        e = VEC[k][31:0];
        chk("R2 valid", 32'(req_valid[ch]), 1);
        chk("R2 addr", req_addr[ch*32 +: 32], w);
        repeat (2) @(negedge clk);
        chk("R2 valid held", 32'(req_valid[ch]), 1);
        take(ch);
        chk("R3 valid dropped", 32'(req_valid[ch]), 0);
        chk("R3 no irq yet", 32'(irq[ch+1]), 0);
        post(ch, e);
        chk("R4 irq", 32'(irq), 32'(1 << (ch+1)));
      end else begin
        e = 5;
        chk("R8 no valid", 32'(req_valid), 0);
        chk("R8 irq", 32'(irq), 32'(1 << (ch+1)));
      end
      rd(8'(4*(ch+1)), v); chk("R4 R8 status", v, e);
      wr(8'(4*(ch+1)), e ^ 32'h2);
      chk("R6 irq kept", 32'(irq[ch+1]), 1);
      rd(8'(4*(ch+1)), v); chk("R6 status kept", v, e);
      wr(8'(4*(((ch+1) % 3)+1)), e);
      chk("R9 other ack", 32'(irq[ch+1]), 1);
      wr(8'(4*(ch+1)), e);
      chk("R5 irq cleared", 32'(irq), 0);
      rd(8'(4*(ch+1)), v); chk("R5 status zero", v, 0);
    end

    // R7 overrun while waiting and while busy
    wr(8'h18, 32'h0000_5001);
    wr(8'h18, 32'h0000_6001);
    chk("R7 addr kept", req_addr[32 +: 32], 32'h0000_5001);
    rd(8'h20, v); chk("R7 overrun set", v, 32'h2);
    // R11 post while still waiting is ignored
    post(1, 1);
    chk("R11 waiting post", 32'(irq), 0);
    chk("R11 still valid", 32'(req_valid), 32'h2);
    wr(8'h20, 32'h2);
    rd(8'h20, v); chk("R7 overrun cleared", v, 0);
    take(1);
    wr(8'h18, 32'h0000_7001);
    rd(8'h20, v); chk("R7 overrun busy", v, 32'h2);
    // R11 post to idle channels
    post(0, 1);
    post(2, 3);
    chk("R11 idle post", 32'(irq), 0);
    rd(8'h04, v); chk("R11 status idle", v, 0);
    post(1, 9);
    chk("R9 only ch1", 32'(irq), 32'h4);
    wr(8'h08, 9);
    wr(8'h20, 32'h7);
    chk("R5 ch1 clear", 32'(irq), 0);

    // R10 event interrupt
    @(negedge clk); evt_post = 1; evt_code = 8'h42;
    @(negedge clk); evt_post = 0;
    chk("R10 irq", 32'(irq), 1);
    rd(8'h00, v); chk("R10 code", v, 32'h42);
    wr(8'h00, 32'h43);
    chk("R10 bad echo", 32'(irq), 1);
    @(negedge clk); evt_post = 1; evt_code = 8'h17;
    @(negedge clk); evt_post = 0;
    rd(8'h00, v); chk("R10 newer code", v, 32'h17);
    wr(8'h00, 32'h17);
    chk("R10 cleared", 32'(irq), 0);
    rd(8'h00, v); chk("R10 code zero", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule